// File: doc/BRIEF.md
# Half-Word Memory Bridge for a 32-bit AHB-Lite Bus

This block is an AHB-Lite slave placed in front of a nonvolatile memory array whose data port is only 16 bits wide. Masters can read and write 8-bit, 16-bit and 32-bit quantities. A 32-bit access is carried out as two back-to-back half-word accesses to the array. For a read, the two halves are joined into one word before the data phase ends. Every valid transfer stalls the bus for a fixed number of wait states by holding `hreadyout` low.

The number of wait states depends on three things: the access direction, the access size, and a FAST/SLOW timing select. That select is sampled in the address phase only. The array is modelled inside the block as a synchronous 16-bit port with per-byte write enables and a one-cycle read latency. Each wait-state count is a parameter and must cover that latency.

Misaligned accesses and sizes wider than a word are refused with a two-cycle ERROR response. IDLE and BUSY slots, and slots where the block is not selected, are answered at once with OKAY and leave the array untouched.

Top module: `ahb_hw16_bridge`

## Requirements
- R1: An 8-bit or 16-bit read holds `hreadyout` low for exactly 2 cycles when `hmode_slow`=0 and 3 cycles when `hmode_slow`=1, then completes with `hresp`=0.
- R2: A 32-bit read holds `hreadyout` low for exactly 5 cycles in FAST mode and 7 in SLOW mode. The result is little-endian: the byte at address A+k appears on `hrdata[8k+7:8k]`, so the lower-address half-word is on `hrdata[15:0]`.
- R3: A write of any size holds `hreadyout` low for exactly 2 cycles in FAST mode and 3 in SLOW mode. It updates only the bytes it addresses, taking byte A from `hwdata` lane A[1:0] (bits 8*A[1:0]+7 down to 8*A[1:0]).
- R4: No valid transfer completes with zero wait states: `hreadyout` is low in the cycle after every accepted NONSEQ or SEQ address phase (`htrans` 2'b10 or 2'b11).
- R5: A narrow read places its data on the lanes it addresses and drives the other lanes to zero. A byte goes to lane `haddr[1:0]`; a half-word goes to bits [15:0] when `haddr[1]`=0 and to [31:16] when it is 1.
- R6: An access is refused if `hsize` is above 2, if it is a half-word (`hsize`=1) with `haddr[0]`=1, or if it is a word (`hsize`=2) with `haddr[1:0]`≠0. A refused access gets `hresp`=1 for two cycles: `hreadyout`=0 in the first and 1 in the second. It does not modify the array.
- R7: IDLE (`htrans`=2'b00) and BUSY (2'b01) slots, and slots with `hsel`=0, get `hreadyout`=1 and `hresp`=0 in the next cycle. They cause no array write.
- R8: The timing select is taken in the address phase; changing `hmode_slow` during the wait states of a transfer does not change that transfer's wait count.
- R9: After reset, `hreadyout`=1, `hresp`=0 and `hrdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| hsel | input | 1 | Slave select |
| haddr | input | ADDR_W | Byte address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 = write |
| hsize | input | 3 | log2 of the transfer size in bytes |
| hwdata | input | 32 | Write data, valid in the data phase |
| hready | input | 1 | Bus-wide ready from the interconnect |
| hmode_slow | input | 1 | 0 = FAST timing, 1 = SLOW timing |
| hreadyout | output | 1 | Slave ready, registered |
| hresp | output | 1 | 0 = OKAY, 1 = ERROR, registered |
| hrdata | output | 32 | Read data, registered |

## Verification
Take the clock edge that accepts an address phase as edge 0, and let N be the wait count. `hreadyout` is low after edges 0 to N-1. The completion values (`hreadyout`=1, `hresp`, `hrdata`) are present after edge N. An ERROR response is low after edge 0 and high, still flagged, after edge 1. An IDLE or BUSY slot shows OKAY after the edge that accepts it.

The bench drives and samples on falling edges. It counts the low cycles between the address phase and the first cycle with `hreadyout` high, and reads data and response in that cycle. It compares both against a byte-wide reference model and an arithmetic wait table. The bound checker applies the same rules with a counter that restarts at every accepted address phase.

// File: rtl/ahb_hw16_pkg.sv
package ahb_hw16_pkg;
  localparam logic [1:0] HT_IDLE   = 2'b00;
  localparam logic [1:0] HT_BUSY   = 2'b01;
  localparam logic [1:0] HT_NONSEQ = 2'b10;
  localparam logic [1:0] HT_SEQ    = 2'b11;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef enum logic [1:0] {
    ST_OPEN = 2'd0,
    ST_XFER = 2'd1,
    ST_ERR  = 2'd2
  } bstate_e;
endpackage

// File: rtl/ee_wait_sel.sv
module ee_wait_sel
  import ahb_hw16_pkg::*;
#(
  parameter int RD_WORD_FAST   = 5,
  parameter int RD_NARROW_FAST = 2,
  parameter int RD_WORD_SLOW   = 7,
  parameter int RD_NARROW_SLOW = 3,
  parameter int WR_FAST        = 2,
  parameter int WR_SLOW        = 3,
  parameter int CNT_W          = 3
) (
  input  logic             is_wr,
  input  logic [1:0]       size,
  input  logic             slow,
  output logic [CNT_W-1:0] nwait
);
  always_comb begin
    if (is_wr) begin
      nwait = slow ? CNT_W'(WR_SLOW) : CNT_W'(WR_FAST);
    end else if (size == SZ_WORD) begin
      nwait = slow ? CNT_W'(RD_WORD_SLOW) : CNT_W'(RD_WORD_FAST);
    end else begin
      nwait = slow ? CNT_W'(RD_NARROW_SLOW) : CNT_W'(RD_NARROW_FAST);
    end
  end
endmodule

// File: rtl/ee_half_ram.sv
module ee_half_ram #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          re,
  input  logic          we,
  input  logic [1:0]    be,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata
);
  localparam int DEPTH = 2 ** AW;

  for (genvar b = 0; b < 2; b++) begin : g_lane
    logic [7:0] cells [DEPTH];
    logic [7:0] q;

    always_ff @(posedge clk) begin
      if (we && be[b]) begin
        cells[addr] <= wdata[b*8 +: 8];
      end
      if (re) begin
        q <= cells[addr];
      end
    end

    assign rdata[b*8 +: 8] = q;
  end
endmodule

// File: rtl/ee_lane_fmt.sv
module ee_lane_fmt
  import ahb_hw16_pkg::*;
(
  input  logic [1:0]  size,
  input  logic [1:0]  addr_lo,
  input  logic        half_sel,
  input  logic [31:0] hwdata,
  input  logic [15:0] half_cur,
  input  logic [15:0] half_lo,
  output logic [15:0] wr_half,
  output logic [1:0]  wr_be,
  output logic [31:0] rd_word
);
  logic [7:0] wr_byte;
  logic [7:0] rd_byte;

  always_comb begin
    wr_byte = hwdata[8*addr_lo +: 8];
    case (size)
      SZ_BYTE: begin
        wr_half = {wr_byte, wr_byte};
        wr_be   = addr_lo[0] ? 2'b10 : 2'b01;
      end
      SZ_HALF: begin
        wr_half = addr_lo[1] ? hwdata[31:16] : hwdata[15:0];
        wr_be   = 2'b11;
      end
      default: begin
        wr_half = half_sel ? hwdata[31:16] : hwdata[15:0];
        wr_be   = 2'b11;
      end
    endcase
  end

  always_comb begin
    rd_byte = addr_lo[0] ? half_cur[15:8] : half_cur[7:0];
    rd_word = '0;
    case (size)
      SZ_BYTE: rd_word[8*addr_lo +: 8] = rd_byte;
      SZ_HALF: rd_word[16*addr_lo[1] +: 16] = half_cur;
      default: rd_word = {half_cur, half_lo};
    endcase
  end
endmodule

// File: rtl/ahb_hw16_bridge.sv
module ahb_hw16_bridge
  import ahb_hw16_pkg::*;
#(
  parameter int ADDR_W         = 10,
  parameter int RD_WORD_FAST   = 5,
  parameter int RD_NARROW_FAST = 2,
  parameter int RD_WORD_SLOW   = 7,
  parameter int RD_NARROW_SLOW = 3,
  parameter int WR_FAST        = 2,
  parameter int WR_SLOW        = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsel,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [2:0]        hsize,
  input  logic [31:0]       hwdata,
  input  logic              hready,
  input  logic              hmode_slow,
  output logic              hreadyout,
  output logic              hresp,
  output logic [31:0]       hrdata
);
  localparam int MAX_RW = (RD_WORD_FAST > RD_WORD_SLOW) ? RD_WORD_FAST : RD_WORD_SLOW;
  localparam int MAX_RN = (RD_NARROW_FAST > RD_NARROW_SLOW) ? RD_NARROW_FAST : RD_NARROW_SLOW;
  localparam int MAX_WR = (WR_FAST > WR_SLOW) ? WR_FAST : WR_SLOW;
  localparam int MAX_R  = (MAX_RW > MAX_RN) ? MAX_RW : MAX_RN;
  localparam int MAX_W  = (MAX_R > MAX_WR) ? MAX_R : MAX_WR;
  localparam int CNT_W  = (MAX_W < 3) ? 2 : $clog2(MAX_W + 1);
  localparam int HALF_AW = ADDR_W - 1;

  bstate_e           state_q;
  logic              hready_q;
  logic              hresp_q;
  logic [31:0]       hrdata_q;
  logic [CNT_W-1:0]  step_q;
  logic [CNT_W-1:0]  nwait_q;
  logic              wr_q;
  logic [1:0]        size_q;
  logic [ADDR_W-1:0] addr_q;
  logic [15:0]       lo_q;

  logic              active;
  logic              misaligned;
  logic [CNT_W-1:0]  nwait_d;
  logic              mem_re;
  logic              mem_we;
  logic [1:0]        mem_be;
  logic [HALF_AW-1:0] mem_addr;
  logic [15:0]       mem_wdata;
  logic [15:0]       mem_rdata;
  logic [31:0]       rd_word;
  logic              second_half;
  logic              first_step;

  assign active = hsel && (htrans == HT_NONSEQ || htrans == HT_SEQ);

  always_comb begin
    misaligned = 1'b0;
    if (hsize > 3'd2) begin
      misaligned = 1'b1;
    end else if (hsize == 3'd1) begin
      misaligned = haddr[0];
    end else if (hsize == 3'd2) begin
      misaligned = |haddr[1:0];
    end
  end

  ee_wait_sel #(
    .RD_WORD_FAST  (RD_WORD_FAST),
    .RD_NARROW_FAST(RD_NARROW_FAST),
    .RD_WORD_SLOW  (RD_WORD_SLOW),
    .RD_NARROW_SLOW(RD_NARROW_SLOW),
    .WR_FAST       (WR_FAST),
    .WR_SLOW       (WR_SLOW),
    .CNT_W         (CNT_W)
  ) i_wait (
    .is_wr(hwrite),
    .size (hsize[1:0]),
    .slow (hmode_slow),
    .nwait(nwait_d)
  );

  assign first_step  = (step_q == CNT_W'(1));
  assign second_half = (step_q == CNT_W'(2)) && (size_q == SZ_WORD);

  always_comb begin
    mem_re = (state_q == ST_XFER) && !wr_q && (first_step || second_half);
    mem_we = (state_q == ST_XFER) &&  wr_q && (first_step || second_half);
    if (size_q == SZ_WORD) begin
      mem_addr = {addr_q[ADDR_W-1:2], second_half};
    end else begin
      mem_addr = addr_q[ADDR_W-1:1];
    end
  end

  ee_lane_fmt i_lane (
    .size    (size_q),
    .addr_lo (addr_q[1:0]),
    .half_sel(second_half),
    .hwdata  (hwdata),
    .half_cur(mem_rdata),
    .half_lo (lo_q),
    .wr_half (mem_wdata),
    .wr_be   (mem_be),
    .rd_word (rd_word)
  );

  ee_half_ram #(
    .AW(HALF_AW)
  ) i_ram (
    .clk  (clk),
    .re   (mem_re),
    .we   (mem_we),
    .be   (mem_be),
    .addr (mem_addr),
    .wdata(mem_wdata),
    .rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_OPEN;
      hready_q <= 1'b1;
      hresp_q  <= 1'b0;
      hrdata_q <= '0;
      step_q   <= '0;
      nwait_q  <= '0;
      wr_q     <= 1'b0;
      size_q   <= SZ_BYTE;
      addr_q   <= '0;
      lo_q     <= '0;
    end else begin
      case (state_q)
        ST_XFER: begin
          if (step_q == CNT_W'(2)) begin
            lo_q <= mem_rdata;
          end
          if (step_q == nwait_q) begin
            state_q  <= ST_OPEN;
            hready_q <= 1'b1;
            hrdata_q <= wr_q ? 32'd0 : rd_word;
          end else begin
            step_q <= step_q + CNT_W'(1);
          end
        end
        ST_ERR: begin
          state_q  <= ST_OPEN;
          hready_q <= 1'b1;
        end
        default: begin
          if (hready) begin
            if (active && misaligned) begin
              state_q  <= ST_ERR;
              hready_q <= 1'b0;
              hresp_q  <= 1'b1;
            end else if (active) begin
              state_q  <= ST_XFER;
              hready_q <= 1'b0;
              hresp_q  <= 1'b0;
              step_q   <= CNT_W'(1);
              nwait_q  <= nwait_d;
              wr_q     <= hwrite;
              size_q   <= hsize[1:0];
              addr_q   <= haddr;
            end else begin
              hresp_q <= 1'b0;
            end
          end
        end
      endcase
    end
  end

  assign hreadyout = hready_q;
  assign hresp     = hresp_q;
  assign hrdata    = hrdata_q;
endmodule

// File: rtl/ahb_hw16_bridge_chk.sv
module ahb_hw16_bridge_chk #(
  parameter int RD_WORD_FAST   = 5,
  parameter int RD_NARROW_FAST = 2,
  parameter int RD_WORD_SLOW   = 7,
  parameter int RD_NARROW_SLOW = 3,
  parameter int WR_FAST        = 2,
  parameter int WR_SLOW        = 3
) (
  input logic        clk,
  input logic        rst,
  input logic        hsel,
  input logic [1:0]  htrans,
  input logic        hwrite,
  input logic [2:0]  hsize,
  input logic [1:0]  haddr_lo,
  input logic        hready,
  input logic        hmode_slow,
  input logic        hreadyout,
  input logic        hresp,
  input logic [31:0] hrdata
);
  localparam logic [1:0] K_BAD = 2'd0, K_RDN = 2'd1, K_RDW = 2'd2, K_WR = 2'd3;

  logic       acc;
  logic       bad;
  logic       pend_q;
  logic [1:0] kind_q;
  logic [3:0] exp_q;
  logic [3:0] cnt_q;
  logic [1:0] sz_q;
  logic [1:0] a_q;
  logic [31:0] keep_mask;

  assign acc = hsel && hready && hreadyout && htrans[1];
  assign bad = (hsize > 3'd2) || (hsize == 3'd1 && haddr_lo[0]) ||
               (hsize == 3'd2 && haddr_lo != 2'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      kind_q <= K_BAD;
      exp_q  <= '0;
      cnt_q  <= '0;
      sz_q   <= '0;
      a_q    <= '0;
    end else if (acc) begin
      pend_q <= 1'b1;
      cnt_q  <= '0;
      sz_q   <= hsize[1:0];
      a_q    <= haddr_lo;
      if (bad) begin
        kind_q <= K_BAD;
        exp_q  <= 4'd1;
      end else if (hwrite) begin
        kind_q <= K_WR;
        exp_q  <= hmode_slow ? 4'(WR_SLOW) : 4'(WR_FAST);
      end else if (hsize == 3'd2) begin
        kind_q <= K_RDW;
        exp_q  <= hmode_slow ? 4'(RD_WORD_SLOW) : 4'(RD_WORD_FAST);
      end else begin
        kind_q <= K_RDN;
        exp_q  <= hmode_slow ? 4'(RD_NARROW_SLOW) : 4'(RD_NARROW_FAST);
      end
    end else if (pend_q) begin
      if (!hreadyout) cnt_q <= cnt_q + 4'd1;
      else            pend_q <= 1'b0;
    end
  end

  always_comb begin
    if (sz_q == 2'd0)      keep_mask = 32'hFF << (8 * a_q);
    else                   keep_mask = 32'hFFFF << (16 * a_q[1]);
  end

  AST_RD_NARROW_WAITS: assert property (@(posedge clk) disable iff (rst)
    pend_q && hreadyout && kind_q == K_RDN |-> cnt_q == exp_q && !hresp); // R1
  AST_RD_WORD_WAITS: assert property (@(posedge clk) disable iff (rst)
    pend_q && hreadyout && kind_q == K_RDW |-> cnt_q == exp_q && !hresp); // R2
  AST_WR_WAITS: assert property (@(posedge clk) disable iff (rst)
    pend_q && hreadyout && kind_q == K_WR |-> cnt_q == exp_q && !hresp); // R3
  AST_NO_ZERO_WAIT: assert property (@(posedge clk) disable iff (rst)
    acc && !bad |=> !hreadyout); // R4
  AST_LANES_ZERO: assert property (@(posedge clk) disable iff (rst)
    pend_q && hreadyout && kind_q == K_RDN |-> (hrdata & ~keep_mask) == 32'd0); // R5
  AST_ERR_FIRST: assert property (@(posedge clk) disable iff (rst)
    acc && bad |=> hresp && !hreadyout); // R6
  AST_ERR_SECOND: assert property (@(posedge clk) disable iff (rst)
    hresp && !hreadyout |=> hresp && hreadyout); // R6
  AST_IDLE_OKAY: assert property (@(posedge clk) disable iff (rst)
    hready && hreadyout && !(hsel && htrans[1]) |=> hreadyout && !hresp); // R7
endmodule

bind ahb_hw16_bridge ahb_hw16_bridge_chk #(
  .RD_WORD_FAST  (RD_WORD_FAST),
  .RD_NARROW_FAST(RD_NARROW_FAST),
  .RD_WORD_SLOW  (RD_WORD_SLOW),
  .RD_NARROW_SLOW(RD_NARROW_SLOW),
  .WR_FAST       (WR_FAST),
  .WR_SLOW       (WR_SLOW)
) i_chk (
  .clk       (clk),
  .rst       (rst),
  .hsel      (hsel),
  .htrans    (htrans),
  .hwrite    (hwrite),
  .hsize     (hsize),
  .haddr_lo  (haddr[1:0]),
  .hready    (hready),
  .hmode_slow(hmode_slow),
  .hreadyout (hreadyout),
  .hresp     (hresp),
  .hrdata    (hrdata)
);

// File: tb/test_ahb_hw16_bridge.sv
module test_ahb_hw16_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 10;
  localparam int REGION = 64;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              hsel = 1'b0;
  logic [ADDR_W-1:0] haddr = '0;
  logic [1:0]        htrans = 2'b00;
  logic              hwrite = 1'b0;
  logic [2:0]        hsize = 3'd0;
  logic [31:0]       hwdata = '0;
  logic              hready;
  logic              hmode_slow = 1'b0;
  logic              hreadyout;
  logic              hresp;
  logic [31:0]       hrdata;

  logic [7:0] mdl [REGION];
  int n_chk = 0;
  int n_fail = 0;

  assign hready = hreadyout;

  always #(CLK_PERIOD/2) clk = ~clk;

  ahb_hw16_bridge #(.ADDR_W(ADDR_W)) i_ahb_hw16_bridge (
    .clk(clk), .rst(rst), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata), .hready(hready),
    .hmode_slow(hmode_slow), .hreadyout(hreadyout), .hresp(hresp), .hrdata(hrdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int exp_waits(input bit wr, input int sz, input bit slow);
    if (wr) return slow ? 3 : 2;
    if (sz == 2) return slow ? 7 : 5;
    return slow ? 3 : 2;
  endfunction

  function automatic logic [31:0] exp_read(input int sz, input int a);
    logic [31:0] w = '0;
    for (int i = 0; i < (1 << sz); i++) w[8*((a+i)%4) +: 8] = mdl[a+i];
    return w;
  endfunction

  task automatic xfer(input bit wr, input int sz, input int a, input logic [31:0] wd,
                      input bit slow, input bit flip, output logic [31:0] rd,
                      output int waits, output bit resp_first, output bit resp_last);
    int guard;
    @(negedge clk);
    hsel = 1'b1; htrans = 2'b10; hwrite = wr; hsize = 3'(sz);
    haddr = ADDR_W'(a); hmode_slow = slow;
    @(negedge clk);
    hsel = 1'b0; htrans = 2'b00; hwdata = wd;
    if (flip) hmode_slow = !slow;
    waits = 0; guard = 0; resp_first = hresp;
    while (!hreadyout && guard < 50) begin
      waits++; guard++;
      @(negedge clk);
    end
    rd = hrdata; resp_last = hresp;
    hmode_slow = slow;
  endtask

  task automatic do_write(input int sz, input int a, input int seed, input bit slow);
    logic [31:0] wd = 32'hC3A5_5A3C ^ 32'(seed);
    logic [31:0] rd; int w; bit r0, r1;
    for (int i = 0; i < (1 << sz); i++) begin
      logic [7:0] b = 8'((a + i) * 13 + seed * 7 + 1);
      wd[8*((a+i)%4) +: 8] = b;
      mdl[a+i] = b;
    end
    xfer(1'b1, sz, a, wd, slow, 1'b0, rd, w, r0, r1);
    chk(w == exp_waits(1'b1, sz, slow), "R3 write waits", 32'(w), 32'(exp_waits(1'b1, sz, slow)));
    chk(!r1, "R3 write resp", 32'(r1), 32'd0);
  endtask

  task automatic do_read(input int sz, input int a, input bit slow, input bit flip, input string req);
    logic [31:0] rd; int w; bit r0, r1;
    xfer(1'b0, sz, a, 32'hDEAD_BEEF, slow, flip, rd, w, r0, r1);
    chk(w == exp_waits(1'b0, sz, slow), {req, " read waits"}, 32'(w), 32'(exp_waits(1'b0, sz, slow)));
    chk(w >= 1, "R4 nonzero waits", 32'(w), 32'd1);
    chk(rd == exp_read(sz, a), {req, " read data"}, rd, exp_read(sz, a));
    chk(!r1, {req, " read resp"}, 32'(r1), 32'd0);
  endtask

  task automatic do_bad(input bit wr, input int sz, input int a);
    logic [31:0] rd; int w; bit r0, r1;
    xfer(wr, sz, a, 32'hFFFF_FFFF, 1'b0, 1'b0, rd, w, r0, r1);
    chk(w == 1, "R6 error low cycles", 32'(w), 32'd1);
    chk(r0 && r1, "R6 error both cycles", {30'd0, r0, r1}, 32'd3);
  endtask

  task automatic idle_slot(input logic [1:0] tr, input bit sel, input int a);
    @(negedge clk);
    hsel = sel; htrans = tr; hwrite = 1'b1; hsize = 3'd2; haddr = ADDR_W'(a);
    @(negedge clk);
    hwdata = 32'h0BAD_F00D;
    chk(hreadyout && !hresp, "R7 idle okay", {30'd0, hreadyout, hresp}, 32'd2);
    hsel = 1'b0; htrans = 2'b00;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog R4 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(hreadyout == 1'b1, "R9 reset ready", 32'(hreadyout), 32'd1);
    chk(hresp == 1'b0, "R9 reset resp", 32'(hresp), 32'd0);
    chk(hrdata == 32'd0, "R9 reset data", hrdata, 32'd0);

    for (int a = 0; a < REGION; a += 4) do_write(2, a, 1, 1'b0);
    for (int s = 0; s < 2; s++) begin
      for (int sz = 0; sz < 3; sz++)
        for (int a = 0; a < 16; a += (1 << sz)) do_write(sz, a, s * 3 + sz + 2, s[0]);
    end
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < REGION; a++) do_read(0, a, s[0], 1'b0, "R1 R5 byte");
      for (int a = 0; a < REGION; a += 2) do_read(1, a, s[0], 1'b0, "R1 R5 half");
      for (int a = 0; a < REGION; a += 4) do_read(2, a, s[0], 1'b0, "R2 word");
    end

    do_read(2, 8, 1'b0, 1'b1, "R8 word fast flip");
    do_read(2, 12, 1'b1, 1'b1, "R8 word slow flip");
    do_read(0, 5, 1'b0, 1'b1, "R8 byte fast flip");
    do_read(1, 6, 1'b1, 1'b1, "R8 half slow flip");

    do_bad(1'b1, 1, 3);
    do_bad(1'b1, 2, 2);
    do_bad(1'b0, 2, 1);
    do_bad(1'b1, 3, 0);
    do_read(2, 0, 1'b0, 1'b0, "R6 array unchanged");

    idle_slot(2'b00, 1'b1, 16);
    idle_slot(2'b01, 1'b1, 16);
    idle_slot(2'b10, 1'b0, 16);
    do_read(2, 16, 1'b0, 1'b0, "R7 array unchanged");

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule